// File: doc/BRIEF.md
# Host Video Mode Switch Shadow

This block sits on a passive tap of a host's 8-bit bus and watches every cycle that goes past. Some bus addresses act as mode switches. When the host touches one of them, the block updates its own copy of that switch. A display generator elsewhere on the chip can then follow the host's text, graphics, paging, column and colour settings without asking the host for them.

The switches that exist depend on the host model. The block supports three families:

- **Base**: only the four basic display pairs.
- **Extended**: adds write-only memory and column switches, a double-resolution switch and an I/O-disable flag.
- **Advanced**: shares the memory and column switches with the extended family, and adds colour, border, monochrome, video-mode and shadow-control registers.

The family can be forced by a configuration input. In auto mode the block leaves the family unknown and examines each write. The first write whose address and data form one of three signatures sets the family. That choice is latched until reset. While the family is unknown, only the basic display pairs respond.

Top module: `vid_switch_shadow`

## Requirements
- R1: After synchronous reset, every flag output is 0, `text_color`, `border_color`, `video_mode` and `shadow_ctl` are 0, and `family` is 0 (unknown) while `cfg_family` is 0.
- R2: A cycle changes state only if `bus_valid` is 1 and `bus_addr[15:7]` equals 9'h180 (addresses 0xC000 to 0xC07F). The switch index is `bus_addr[6:0]`. All other cycles leave every output unchanged. Every update appears on the outputs one clock after the qualifying cycle.
- R3: Indices 0x50/0x51 clear/set `text_mode`, 0x52/0x53 clear/set `mixed_mode`, 0x54/0x55 clear/set `page2_sel`, and 0x56/0x57 clear/set `hires_mode`. These respond to reads and writes in every family, including unknown.
- R4: When `family` is 2 or 3 and the cycle is a write (`bus_rd`=0), the even index of a pair clears and the odd index sets: 0x00/0x01 `store80`, 0x04/0x05 `aux_write`, 0x08/0x09 `aux_zpage`, 0x0C/0x0D `col80`, 0x0E/0x0F `alt_charset`. Reads, and any access in family 0 or 1, leave these flags unchanged.
- R5: When `family` is 2 or 3, index 0x5E sets and index 0x5F clears `dbl_lores`, on reads and writes alike. In family 0 or 1 these indices have no effect.
- R6: Only when `family` is 3, and only on writes: 0x21 copies `bus_data[7]` to `mono`; 0x22 loads `text_color` with the data byte; 0x29 loads `video_mode` with the low VIDMODE_W data bits; 0x34 loads `border_color` with `bus_data[3:0]`; 0x35 loads `shadow_ctl` with the low SHADOW_W data bits.
- R7: Only when `family` is 2, and only on writes, index 0x7E sets `io_disable` and index 0x7F clears it.
- R8: When `cfg_family` is nonzero (1 base, 2 extended, 3 advanced), `family` equals `cfg_family` in the same cycle, and signature detection does not run.
- R9: When `cfg_family` is 0 and the family is still unknown, each write forms the word {`bus_addr`, 6'b0, 1'b0, 1'b1, `bus_data`}. The value 0xC0330100 selects family 3, 0x01F901FB selects family 1, and 0x01F5018B selects family 2. Any other write is discarded and the next write is tried. Reads never detect. The detecting write itself is decoded with the previous family.
- R10: Once detected, `family` holds its value until reset, whatever signatures follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_family | input | 2 | 0 auto-detect, 1 base, 2 extended, 3 advanced |
| bus_valid | input | 1 | A host bus cycle is present this clock |
| bus_addr | input | 16 | Host bus address |
| bus_data | input | 8 | Host bus data byte |
| bus_rd | input | 1 | 1 read, 0 write |
| family | output | 2 | Family in use (0 unknown, 1 base, 2 extended, 3 advanced) |
| text_mode | output | 1 | Text display selected |
| mixed_mode | output | 1 | Mixed text/graphics |
| page2_sel | output | 1 | Second display page |
| hires_mode | output | 1 | High-resolution graphics |
| store80 | output | 1 | 80-column store paging |
| aux_write | output | 1 | Writes go to auxiliary bank |
| aux_zpage | output | 1 | Auxiliary zero page and stack |
| col80 | output | 1 | 80-column display |
| alt_charset | output | 1 | Alternate character set |
| dbl_lores | output | 1 | Double low-resolution graphics |
| io_disable | output | 1 | I/O disable flag |
| mono | output | 1 | Monochrome display |
| text_color | output | 8 | Text/background colour byte |
| border_color | output | 4 | Border colour |
| video_mode | output | VIDMODE_W | Video-mode field |
| shadow_ctl | output | SHADOW_W | Shadow-control field |

## Verification
Each switch, register and detection update is captured at the clock edge that samples the bus cycle. The new value is visible on the outputs for the whole following clock period. `family` is the one exception: it follows `cfg_family` combinationally, and a detection becomes visible one clock after the signature write. The bench drives inputs on the falling edge and updates its reference model on the rising edge from the same inputs. It compares every output on the next falling edge, which is exactly one clock after each stimulus. The same comparison therefore also confirms that nothing moved in cycles that should have no effect.

// File: rtl/vss_pkg.sv
`timescale 1ns/1ps
package vss_pkg;

    typedef enum logic [1:0] {
        FAM_NONE = 2'd0,
        FAM_BASE = 2'd1,
        FAM_EXT  = 2'd2,
        FAM_ADV  = 2'd3
    } fam_e;

    localparam int NFLAG = 12;
    typedef logic [3:0] fidx_t;

    localparam fidx_t F_TEXT    = 4'd0;
    localparam fidx_t F_MIXED   = 4'd1;
    localparam fidx_t F_PAGE2   = 4'd2;
    localparam fidx_t F_HIRES   = 4'd3;
    localparam fidx_t F_STORE80 = 4'd4;
    localparam fidx_t F_AUXWR   = 4'd5;
    localparam fidx_t F_AUXZP   = 4'd6;
    localparam fidx_t F_COL80   = 4'd7;
    localparam fidx_t F_ALTCHR  = 4'd8;
    localparam fidx_t F_DLR     = 4'd9;
    localparam fidx_t F_IODIS   = 4'd10;
    localparam fidx_t F_MONO    = 4'd11;
    localparam fidx_t FIDX_NONE = 4'd15;

    localparam logic [8:0]  WIN_TAG  = 9'h180;
    localparam logic [31:0] SIG_ADV  = 32'hC033_0100;
    localparam logic [31:0] SIG_BASE = 32'h01F9_01FB;
    localparam logic [31:0] SIG_EXT  = 32'h01F5_018B;

    typedef struct packed {
        logic [NFLAG-1:0] set;
        logic [NFLAG-1:0] clr;
        logic             ld_color;
        logic             ld_vmode;
        logic             ld_border;
        logic             ld_shadow;
    } upd_t;

    function automatic logic [31:0] sig_word(input logic [15:0] a, input logic [7:0] d);
        return {a, 6'b0, 1'b0, 1'b1, d};
    endfunction

    function automatic fam_e sig_family(input logic [31:0] w);
        fam_e f;
        case (w)
            SIG_ADV:  f = FAM_ADV;
            SIG_BASE: f = FAM_BASE;
            SIG_EXT:  f = FAM_EXT;
            default:  f = FAM_NONE;
        endcase
        return f;
    endfunction

    function automatic logic fam_is_ext(input fam_e f);
        return (f == FAM_EXT) || (f == FAM_ADV);
    endfunction

    function automatic fidx_t base_flag(input logic [1:0] p);
        fidx_t r;
        case (p)
            2'd0:    r = F_TEXT;
            2'd1:    r = F_MIXED;
            2'd2:    r = F_PAGE2;
            default: r = F_HIRES;
        endcase
        return r;
    endfunction

    function automatic fidx_t ext_pair(input logic [2:0] p);
        fidx_t r;
        case (p)
            3'd0:    r = F_STORE80;
            3'd2:    r = F_AUXWR;
            3'd4:    r = F_AUXZP;
            3'd6:    r = F_COL80;
            3'd7:    r = F_ALTCHR;
            default: r = FIDX_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vss_family_detect.sv
`timescale 1ns/1ps
module vss_family_detect
    import vss_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_family,
    input  logic        bus_valid,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_data,
    input  logic        bus_rd,
    output fam_e        fam
);

    fam_e det_q;
    logic auto_mode;
    logic try_detect;

    assign auto_mode  = (cfg_family == 2'd0);
    assign try_detect = auto_mode && (det_q == FAM_NONE) && bus_valid && !bus_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            det_q <= FAM_NONE;
        end else if (try_detect) begin
            det_q <= sig_family(sig_word(bus_addr, bus_data));
        end
    end

    assign fam = auto_mode ? det_q : fam_e'(cfg_family);

endmodule

// File: rtl/vss_switch_decode.sv
`timescale 1ns/1ps
module vss_switch_decode
    import vss_pkg::*;
(
    input  logic        bus_valid,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_data,
    input  logic        bus_rd,
    input  fam_e        fam,
    output upd_t        upd
);

    logic [6:0] idx;
    logic       hit;
    logic       wr;
    fidx_t      bf;
    fidx_t      pf;

    assign idx = bus_addr[6:0];
    assign hit = bus_valid && (bus_addr[15:7] == WIN_TAG);
    assign wr  = !bus_rd;
    assign bf  = base_flag(idx[2:1]);
    assign pf  = ext_pair(idx[3:1]);

    always_comb begin
        upd = '0;
        if (hit) begin
            // basic display pairs: any access, any family
            if (idx[6:3] == 4'hA) begin
                if (idx[0]) upd.set[bf] = 1'b1;
                else        upd.clr[bf] = 1'b1;
            end
            // write-only memory/column pairs
            if (fam_is_ext(fam) && wr && (idx[6:4] == 3'd0) && (pf != FIDX_NONE)) begin
                if (idx[0]) upd.set[pf] = 1'b1;
                else        upd.clr[pf] = 1'b1;
            end
            // double low-res: any access
            if (fam_is_ext(fam)) begin
                if (idx == 7'h5E) upd.set[F_DLR] = 1'b1;
                if (idx == 7'h5F) upd.clr[F_DLR] = 1'b1;
            end
            // advanced-only register writes
            if ((fam == FAM_ADV) && wr) begin
                case (idx)
                    7'h21: begin
                        if (bus_data[7]) upd.set[F_MONO] = 1'b1;
                        else             upd.clr[F_MONO] = 1'b1;
                    end
                    7'h22:   upd.ld_color  = 1'b1;
                    7'h29:   upd.ld_vmode  = 1'b1;
                    7'h34:   upd.ld_border = 1'b1;
                    7'h35:   upd.ld_shadow = 1'b1;
                    default: ;
                endcase
            end
            // extended-only I/O disable
            if ((fam == FAM_EXT) && wr) begin
                if (idx == 7'h7E) upd.set[F_IODIS] = 1'b1;
                if (idx == 7'h7F) upd.clr[F_IODIS] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vss_switch_regs.sv
`timescale 1ns/1ps
module vss_switch_regs
    import vss_pkg::*;
#(
    parameter int VIDMODE_W = 8,
    parameter int SHADOW_W  = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  upd_t                 upd,
    input  logic [7:0]           bus_data,
    output logic [NFLAG-1:0]     flags,
    output logic [7:0]           color_q,
    output logic [3:0]           border_q,
    output logic [VIDMODE_W-1:0] vmode_q,
    output logic [SHADOW_W-1:0]  shadow_q
);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flags[i] <= 1'b0;
            else if (upd.set[i]) flags[i] <= 1'b1;
            else if (upd.clr[i]) flags[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            color_q  <= '0;
            border_q <= '0;
            vmode_q  <= '0;
            shadow_q <= '0;
        end else begin
            if (upd.ld_color)  color_q  <= bus_data;
            if (upd.ld_border) border_q <= bus_data[3:0];
            if (upd.ld_vmode)  vmode_q  <= bus_data[VIDMODE_W-1:0];
            if (upd.ld_shadow) shadow_q <= bus_data[SHADOW_W-1:0];
        end
    end

endmodule

// File: rtl/vid_switch_shadow.sv
`timescale 1ns/1ps
module vid_switch_shadow
    import vss_pkg::*;
#(
    parameter int VIDMODE_W = 8,
    parameter int SHADOW_W  = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           cfg_family,
    input  logic                 bus_valid,
    input  logic [15:0]          bus_addr,
    input  logic [7:0]           bus_data,
    input  logic                 bus_rd,
    output logic [1:0]           family,
    output logic                 text_mode,
    output logic                 mixed_mode,
    output logic                 page2_sel,
    output logic                 hires_mode,
    output logic                 store80,
    output logic                 aux_write,
    output logic                 aux_zpage,
    output logic                 col80,
    output logic                 alt_charset,
    output logic                 dbl_lores,
    output logic                 io_disable,
    output logic                 mono,
    output logic [7:0]           text_color,
    output logic [3:0]           border_color,
    output logic [VIDMODE_W-1:0] video_mode,
    output logic [SHADOW_W-1:0]  shadow_ctl
);

    fam_e             fam;
    upd_t             upd;
    logic [NFLAG-1:0] flags;

    vss_family_detect u_detect (
        .clk        (clk),
        .rst        (rst),
        .cfg_family (cfg_family),
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .bus_rd     (bus_rd),
        .fam        (fam)
    );

    vss_switch_decode u_decode (
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .bus_rd    (bus_rd),
        .fam       (fam),
        .upd       (upd)
    );

    vss_switch_regs #(
        .VIDMODE_W (VIDMODE_W),
        .SHADOW_W  (SHADOW_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .upd      (upd),
        .bus_data (bus_data),
        .flags    (flags),
        .color_q  (text_color),
        .border_q (border_color),
        .vmode_q  (video_mode),
        .shadow_q (shadow_ctl)
    );

    assign family      = fam;
    assign text_mode   = flags[F_TEXT];
    assign mixed_mode  = flags[F_MIXED];
    assign page2_sel   = flags[F_PAGE2];
    assign hires_mode  = flags[F_HIRES];
    assign store80     = flags[F_STORE80];
    assign aux_write   = flags[F_AUXWR];
    assign aux_zpage   = flags[F_AUXZP];
    assign col80       = flags[F_COL80];
    assign alt_charset = flags[F_ALTCHR];
    assign dbl_lores   = flags[F_DLR];
    assign io_disable  = flags[F_IODIS];
    assign mono        = flags[F_MONO];

endmodule

// File: rtl/vss_checker.sv
`timescale 1ns/1ps
module vss_checker #(
    parameter int VIDMODE_W = 8,
    parameter int SHADOW_W  = 7
) (
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           cfg_family,
    input logic                 bus_valid,
    input logic [15:0]          bus_addr,
    input logic [7:0]           bus_data,
    input logic                 bus_rd,
    input logic [1:0]           family,
    input logic                 text_mode,
    input logic                 store80,
    input logic                 aux_write,
    input logic                 aux_zpage,
    input logic                 col80,
    input logic                 alt_charset,
    input logic                 dbl_lores,
    input logic                 io_disable,
    input logic                 mono,
    input logic [7:0]           text_color,
    input logic [3:0]           border_color,
    input logic [VIDMODE_W-1:0] video_mode,
    input logic [SHADOW_W-1:0]  shadow_ctl
);

    logic [4:0] wonly;
    assign wonly = {store80, aux_write, aux_zpage, col80, alt_charset};

    AST_OUTSIDE_WINDOW_QUIET: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_addr[15:7] != 9'h180) |=>
            ($stable(text_mode) && $stable(wonly) && $stable(dbl_lores) && $stable(mono)
             && $stable(text_color) && $stable(border_color) && $stable(video_mode)
             && $stable(shadow_ctl))); // R2

    AST_TEXT_ON: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_addr == 16'hC051) |=> text_mode); // R3

    AST_TEXT_OFF: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_addr == 16'hC050) |=> !text_mode); // R3

    AST_WRITE_ONLY_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_rd && bus_addr[15:4] == 12'hC00) |=> $stable(wonly)); // R4

    AST_DLR_NEEDS_EXT: assert property (@(posedge clk) disable iff (rst)
        (family < 2'd2) |=> $stable(dbl_lores)); // R5

    AST_BORDER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_rd && bus_addr == 16'hC034 && family == 2'd3)
            |=> (border_color == $past(bus_data[3:0]))); // R6

    AST_IODIS_EXT_ONLY: assert property (@(posedge clk) disable iff (rst)
        (family != 2'd2) |=> $stable(io_disable)); // R7

    AST_FORCED_FAMILY: assert property (@(posedge clk) disable iff (rst)
        (cfg_family != 2'd0) |-> (family == cfg_family)); // R8

    AST_FAMILY_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (cfg_family == 2'd0 && family != 2'd0)
            |=> (cfg_family != 2'd0 || $stable(family))); // R10

endmodule

bind vid_switch_shadow vss_checker #(
    .VIDMODE_W (VIDMODE_W),
    .SHADOW_W  (SHADOW_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_family   (cfg_family),
    .bus_valid    (bus_valid),
    .bus_addr     (bus_addr),
    .bus_data     (bus_data),
    .bus_rd       (bus_rd),
    .family       (family),
    .text_mode    (text_mode),
    .store80      (store80),
    .aux_write    (aux_write),
    .aux_zpage    (aux_zpage),
    .col80        (col80),
    .alt_charset  (alt_charset),
    .dbl_lores    (dbl_lores),
    .io_disable   (io_disable),
    .mono         (mono),
    .text_color   (text_color),
    .border_color (border_color),
    .video_mode   (video_mode),
    .shadow_ctl   (shadow_ctl)
);

// File: tb/vid_switch_shadow_tb.sv
`timescale 1ns/1ps
module vid_switch_shadow_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg = 2'd0;
    logic        valid = 1'b0;
    logic [15:0] addr = 16'h0;
    logic [7:0]  data = 8'h0;
    logic        rd = 1'b1;

    logic [1:0] family;
    logic text_mode, mixed_mode, page2_sel, hires_mode, store80, aux_write, aux_zpage;
    logic col80, alt_charset, dbl_lores, io_disable, mono;
    logic [7:0] text_color;
    logic [3:0] border_color;
    logic [7:0] video_mode;
    logic [6:0] shadow_ctl;

    vid_switch_shadow u_dut (
        .clk(clk), .rst(rst), .cfg_family(cfg), .bus_valid(valid), .bus_addr(addr),
        .bus_data(data), .bus_rd(rd), .family(family), .text_mode(text_mode),
        .mixed_mode(mixed_mode), .page2_sel(page2_sel), .hires_mode(hires_mode),
        .store80(store80), .aux_write(aux_write), .aux_zpage(aux_zpage), .col80(col80),
        .alt_charset(alt_charset), .dbl_lores(dbl_lores), .io_disable(io_disable),
        .mono(mono), .text_color(text_color), .border_color(border_color),
        .video_mode(video_mode), .shadow_ctl(shadow_ctl)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    armed  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit m_text, m_mixed, m_page2, m_hires, m_s80, m_auxw, m_auxz, m_c80, m_alt;
    bit m_dlr, m_iod, m_mono;
    int m_color, m_border, m_vmode, m_shadow, m_det;

    function automatic int exp_family();
        return (cfg != 0) ? int'(cfg) : m_det;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            {m_text, m_mixed, m_page2, m_hires, m_s80, m_auxw, m_auxz, m_c80, m_alt} = '0;
            {m_dlr, m_iod, m_mono} = '0;
            m_color = 0; m_border = 0; m_vmode = 0; m_shadow = 0; m_det = 0;
        end else if (valid) begin
            int  fam;
            bit  ext, adv, wr;
            fam = exp_family();
            ext = (fam >= 2);
            adv = (fam == 3);
            wr  = !rd;
            if (addr >= 16'hC000 && addr <= 16'hC07F) begin
                case (int'(addr) - 'hC000)
                    'h50: m_text  = 0;
                    'h51: m_text  = 1;
                    'h52: m_mixed = 0;
                    'h53: m_mixed = 1;
                    'h54: m_page2 = 0;
                    'h55: m_page2 = 1;
                    'h56: m_hires = 0;
                    'h57: m_hires = 1;
                    'h00: if (ext && wr) m_s80  = 0;
                    'h01: if (ext && wr) m_s80  = 1;
                    'h04: if (ext && wr) m_auxw = 0;
                    'h05: if (ext && wr) m_auxw = 1;
                    'h08: if (ext && wr) m_auxz = 0;
                    'h09: if (ext && wr) m_auxz = 1;
                    'h0C: if (ext && wr) m_c80  = 0;
                    'h0D: if (ext && wr) m_c80  = 1;
                    'h0E: if (ext && wr) m_alt  = 0;
                    'h0F: if (ext && wr) m_alt  = 1;
                    'h5E: if (ext) m_dlr = 1;
                    'h5F: if (ext) m_dlr = 0;
                    'h21: if (adv && wr) m_mono   = data[7];
                    'h22: if (adv && wr) m_color  = data;
                    'h29: if (adv && wr) m_vmode  = data;
                    'h34: if (adv && wr) m_border = data % 16;
                    'h35: if (adv && wr) m_shadow = data % 128;
                    'h7E: if (fam == 2 && wr) m_iod = 1;
                    'h7F: if (fam == 2 && wr) m_iod = 0;
                    default: ;
                endcase
            end
            if (wr && cfg == 0 && m_det == 0) begin
                longint sig;
                sig = (longint'(addr) << 16) + 'h100 + data;
                if (sig == 'hC0330100)      m_det = 3;
                else if (sig == 'h01F901FB) m_det = 1;
                else if (sig == 'h01F5018B) m_det = 2;
            end
        end
    end

    task automatic chk(input string name, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0h expected %0h", cur_req, name, got, exp);
        end
    endtask

    // compare every output one clock after each stimulus, away from the rising edge
    always @(negedge clk) begin
        if (armed && !done) begin
            chk("family R8/R9/R10", family, exp_family());
            chk("text_mode R3", text_mode, m_text);
            chk("mixed_mode R3", mixed_mode, m_mixed);
            chk("page2_sel R3", page2_sel, m_page2);
            chk("hires_mode R3", hires_mode, m_hires);
            chk("store80 R4", store80, m_s80);
            chk("aux_write R4", aux_write, m_auxw);
            chk("aux_zpage R4", aux_zpage, m_auxz);
            chk("col80 R4", col80, m_c80);
            chk("alt_charset R4", alt_charset, m_alt);
            chk("dbl_lores R5", dbl_lores, m_dlr);
            chk("io_disable R7", io_disable, m_iod);
            chk("mono R6", mono, m_mono);
            chk("text_color R6", text_color, m_color);
            chk("border_color R6", border_color, m_border);
            chk("video_mode R6", video_mode, m_vmode);
            chk("shadow_ctl R6", shadow_ctl, m_shadow);
        end
    end

    task automatic acc(input logic [15:0] a, input logic [7:0] d, input logic r);
        @(negedge clk);
        valid = 1'b1; addr = a; data = d; rd = r;
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        acc(a, d, 1'b0);
    endtask

    task automatic rdc(input logic [15:0] a);
        acc(a, 8'h5A, 1'b1);
    endtask

    task automatic do_reset(input logic [1:0] c);
        @(negedge clk);
        rst = 1'b1; cfg = c; valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state, auto mode
        do_reset(2'd0);
        armed = 1;
        cur_req = "R1";
        repeat (2) @(negedge clk);

        // R2: addresses outside the switch window do nothing
        cur_req = "R2";
        wr(16'hC080, 8'h00); wr(16'hD051, 8'h00); rdc(16'h4051); wr(16'hC151, 8'hFF);
        // R3: basic pairs work while family unknown, reads and writes
        cur_req = "R3";
        rdc(16'hC051); rdc(16'hC053); wr(16'hC055, 8'h00); wr(16'hC057, 8'h00);
        rdc(16'hC052); wr(16'hC050, 8'h11);
        // R4/R5: extended switches ignored before detection
        cur_req = "R4";
        wr(16'hC001, 8'h00); wr(16'hC00D, 8'h00);
        cur_req = "R5";
        rdc(16'hC05E);

        // R9: discard non-signature write and a read that matches a signature
        cur_req = "R9";
        wr(16'h1234, 8'h55);
        acc(16'h01F5, 8'h8B, 1'b1);
        wr(16'h01F5, 8'h8B);           // extended selected
        // R4: write-only pairs now live, reads ignored
        cur_req = "R4";
        wr(16'hC001, 8'h00); rdc(16'hC000); wr(16'hC005, 8'h00); wr(16'hC009, 8'h00);
        wr(16'hC00D, 8'h00); wr(16'hC00F, 8'h00); rdc(16'hC00E); wr(16'hC004, 8'h00);
        // R5: double low-res on reads
        cur_req = "R5";
        rdc(16'hC05E); wr(16'hC05F, 8'h00); wr(16'hC05E, 8'h00);
        // R7: I/O disable on extended, reads ignored
        cur_req = "R7";
        wr(16'hC07E, 8'h00); rdc(16'hC07F); wr(16'hC07F, 8'h00); wr(16'hC07E, 8'h00);
        // R6: advanced registers ignored on extended
        cur_req = "R6";
        wr(16'hC034, 8'h0C); wr(16'hC022, 8'hF1);
        // R10: later signatures do not change the family
        cur_req = "R10";
        wr(16'hC033, 8'h00); wr(16'h01F9, 8'hFB); rdc(16'hC034);

        // R8: forced advanced
        do_reset(2'd3);
        cur_req = "R8";
        wr(16'h01F5, 8'h8B);
        cur_req = "R6";
        wr(16'hC021, 8'h80); wr(16'hC022, 8'hA5); wr(16'hC029, 8'hC3);
        wr(16'hC034, 8'hAB); wr(16'hC035, 8'hFE); rdc(16'hC022); rdc(16'hC021);
        wr(16'hC021, 8'h7F);
        cur_req = "R7";
        wr(16'hC07E, 8'h00);
        cur_req = "R4";
        wr(16'hC00D, 8'h00); wr(16'hC001, 8'h00);

        // R9: advanced signature in auto mode, then its registers
        do_reset(2'd0);
        cur_req = "R9";
        wr(16'hC033, 8'h00);
        cur_req = "R6";
        wr(16'hC034, 8'h05); wr(16'hC035, 8'h81);

        // R9: base signature, extended switches stay dead
        do_reset(2'd0);
        cur_req = "R9";
        wr(16'h01F9, 8'hFB);
        cur_req = "R4";
        wr(16'hC001, 8'h00); wr(16'hC05E, 8'h00); wr(16'hC07E, 8'h00);

        // R2: random traffic across all forced families and auto
        cur_req = "R2";
        for (int c = 0; c < 4; c++) begin
            do_reset(c[1:0]);
            for (int n = 0; n < 1500; n++) begin
                logic [15:0] a;
                logic [7:0]  d;
                int          pick;
                pick = $urandom_range(0, 99);
                d = 8'($urandom);
                if (pick < 70)      a = 16'hC000 | 16'($urandom_range(0, 127));
                else if (pick < 73) begin a = 16'h01F5; d = 8'h8B; end
                else if (pick < 76) begin a = 16'hC033; d = 8'h00; end
                else                a = 16'($urandom);
                @(negedge clk);
                valid = ($urandom_range(0, 3) != 0);
                addr = a; data = d; rd = $urandom_range(0, 1) != 0;
            end
            @(negedge clk);
            valid = 1'b0;
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule